// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block holds the two programmable offsets that a FIFO's flag logic compares against its fill level. One offset sets the almost-empty threshold and the other sets the almost-full threshold. Both are always presented at the outputs for the comparators, which sit outside this block. At master reset the offsets take default values set by parameters.

Software or a controller can set the offsets in two ways. The first is a serial bit stream on the write clock, which writes one bit per edge. The second is a byte-wide parallel write port on the write clock, which takes one byte per edge. The stored values can be read back one byte per read-clock edge. All three access methods are gated by a common load input. Each method keeps its own position in a fixed register order. That position returns to the start whenever load is dropped. The offset width is a parameter (default 18 bits). Each offset therefore spans ceil(width/8) bytes, which is three bytes at the default width.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ae_ofs` equals `DEF_AE`, `af_ofs` equals `DEF_AF` and `rd_q` is 0. The write, serial and read positions all start at their first step.
- R2: On each `wclk` edge with `ld`=1, `sen`=1 and `wen`=0, the value of `si` is stored at the next serial bit position. Positions 0..W-1 are bits 0..W-1 of the almost-empty offset. Positions W..2W-1 are bits 0..W-1 of the almost-full offset. After position 2W-1 the next position is 0.
- R3: On each `wclk` edge with `ld`=1 and `wen`=1, `wr_d` is stored into the byte at the current write step, and the step advances. With NB = ceil(W/8), steps 0..NB-1 are bytes 0 (bits 7:0) up to NB-1 of the almost-empty offset. Steps NB..2NB-1 are the same bytes of the almost-full offset. After step 2NB-1 the next step is 0.
- R4: Bits of the most significant byte that lie at or above bit position W are discarded on a parallel write. They read back as 0.
- R5: On each `rclk` edge with `ld`=1 and `ren`=1, `rd_q` takes the byte at the current read step, using the step order of R3, and the read step advances with the same wrap. On any other `rclk` edge `rd_q` keeps its value.
- R6: A write-clock edge that sees `ld`=0 returns the write and serial positions to step 0. A read-clock edge that sees `ld`=0 returns the read position to step 0.
- R7: When `ld`, `wen` and `sen` are all 1 on a `wclk` edge, only the parallel write takes place. No serial bit is stored and the serial position does not move.
- R8: With `ld`=0, the inputs `wen`, `sen`, `si`, `wr_d` and `ren` change neither offset nor `rd_q`.
- R9: Within one load session, the read step is independent of the write step. A parallel write does not move the read step, and a read does not move the write step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; clocks serial and parallel loading |
| rclk | input | 1 | Read clock; clocks readback |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ld | input | 1 | Load select; enables offset access |
| wen | input | 1 | Write enable; parallel byte write when `ld` is high |
| sen | input | 1 | Serial enable; serial bit shift when `ld` is high |
| si | input | 1 | Serial data bit |
| wr_d | input | 8 | Parallel write data byte |
| ren | input | 1 | Read enable; byte readback when `ld` is high |
| rd_q | output | 8 | Readback data byte |
| ae_ofs | output | W | Almost-empty offset to the flag comparators |
| af_ofs | output | W | Almost-full offset to the flag comparators |

## Verification
The bench targets the wrap from the last step back to the first on all three paths. A design that got this wrong would spill a seventh byte, or a (2W+1)th bit, into the almost-full offset or lose it, rather than overwrite almost-empty byte 0 or bit 0. It also drops `ld` in the middle of a sequence. A missing restart would send the next byte to the middle of an offset. It writes all-ones into the most significant byte and expects the bits above the width to read back as zero; an unmasked design would return stale ones. Finally it asserts `wen` and `sen` together, and interleaves reads with writes in one session. These cases expose a serial counter that creeps when it should not, and position counters that share state.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

  localparam int MAXW = 32;
  typedef logic [MAXW-1:0] word_t;

  // Byte idx (0 = bits 7:0) of a word.
  function automatic logic [7:0] pick_byte(word_t v, int idx);
    return v[idx*8 +: 8];
  endfunction

  // Replace byte idx of a word.
  function automatic word_t place_byte(word_t v, int idx, logic [7:0] b);
    word_t r;
    r = v;
    r[idx*8 +: 8] = b;
    return r;
  endfunction

  // Ones in the low w bits.
  function automatic word_t width_mask(int w);
    word_t m;
    for (int i = 0; i < MAXW; i++) m[i] = (i < w);
    return m;
  endfunction

  // Number of bytes needed to hold w bits.
  function automatic int byte_count(int w);
    return (w + 7) / 8;
  endfunction

endpackage

// File: rtl/ofsld_wr_seq.sv
module ofsld_wr_seq #(
  parameter int OFS_W = 18,
  parameter int NSTEP = 6,
  parameter int SP_W  = 3,
  parameter int SB_W  = 6
) (
  input  logic            wclk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic            wen,
  input  logic            sen,
  output logic            par_we,
  output logic            ser_we,
  output logic [SP_W-1:0] wstep,
  output logic [SB_W-1:0] sbit
);

  localparam logic [SP_W-1:0] STEP_LAST = SP_W'(NSTEP - 1);
  localparam logic [SB_W-1:0] BIT_LAST  = SB_W'(2 * OFS_W - 1);

  // Parallel access wins over serial access.
  assign par_we = ld & wen;
  assign ser_we = ld & sen & ~wen;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wstep <= '0;
      sbit  <= '0;
    end else if (!ld) begin
      wstep <= '0;
      sbit  <= '0;
    end else begin
      if (par_we) wstep <= (wstep == STEP_LAST) ? '0 : wstep + 1'b1;
      if (ser_we) sbit  <= (sbit == BIT_LAST) ? '0 : sbit + 1'b1;
    end
  end

  AST_WSTEP_RANGE: assert property (@(posedge wclk) disable iff (!rst_n)
    wstep <= STEP_LAST);  // R3
  AST_SBIT_RANGE: assert property (@(posedge wclk) disable iff (!rst_n)
    sbit <= BIT_LAST);  // R2
  AST_WR_RESTART: assert property (@(posedge wclk) disable iff (!rst_n)
    !ld |=> (wstep == '0) && (sbit == '0));  // R6
  AST_SER_HELD: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld && wen) |=> $stable(sbit));  // R7

endmodule

// File: rtl/ofsld_regs.sv
module ofsld_regs
  import ofsld_pkg::*;
#(
  parameter int               OFS_W  = 18,
  parameter int               NB     = 3,
  parameter int               SP_W   = 3,
  parameter int               SB_W   = 6,
  parameter logic [OFS_W-1:0] DEF_AE = '0,
  parameter logic [OFS_W-1:0] DEF_AF = '0
) (
  input  logic             wclk,
  input  logic             rst_n,
  input  logic             par_we,
  input  logic             ser_we,
  input  logic [SP_W-1:0]  wstep,
  input  logic [SB_W-1:0]  sbit,
  input  logic [7:0]       wr_d,
  input  logic             si,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);

  logic [OFS_W-1:0] ae_q, af_q;
  word_t ae_w, af_w, ae_n, af_n, tgt, upd;
  logic  pick_af, spick_af;
  int    bidx, sidx;

  always_comb begin
    ae_w     = word_t'(ae_q);
    af_w     = word_t'(af_q);
    pick_af  = (int'(wstep) >= NB);
    bidx     = pick_af ? int'(wstep) - NB : int'(wstep);
    spick_af = (int'(sbit) >= OFS_W);
    sidx     = spick_af ? int'(sbit) - OFS_W : int'(sbit);
    ae_n     = ae_w;
    af_n     = af_w;
    tgt      = pick_af ? af_w : ae_w;
    upd      = place_byte(tgt, bidx, wr_d) & width_mask(OFS_W);
    if (par_we) begin
      if (pick_af) af_n = upd;
      else         ae_n = upd;
    end else if (ser_we) begin
      if (spick_af) af_n[sidx[4:0]] = si;
      else          ae_n[sidx[4:0]] = si;
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q <= DEF_AE;
      af_q <= DEF_AF;
    end else begin
      ae_q <= ae_n[OFS_W-1:0];
      af_q <= af_n[OFS_W-1:0];
    end
  end

  assign ae_ofs = ae_q;
  assign af_ofs = af_q;

  AST_IDLE_HOLD: assert property (@(posedge wclk) disable iff (!rst_n)
    !(par_we || ser_we) |=> $stable(ae_q) && $stable(af_q));  // R8
  AST_PAR_AE_ONLY: assert property (@(posedge wclk) disable iff (!rst_n)
    (par_we && int'(wstep) < NB) |=> $stable(af_q));  // R3
  AST_PAR_AF_ONLY: assert property (@(posedge wclk) disable iff (!rst_n)
    (par_we && int'(wstep) >= NB) |=> $stable(ae_q));  // R3
  AST_SER_ONE_BIT: assert property (@(posedge wclk) disable iff (!rst_n)
    (ser_we && !par_we) |=> ($countones({ae_q ^ $past(ae_q), af_q ^ $past(af_q)}) <= 1));  // R2

endmodule

// File: rtl/ofsld_rd_port.sv
module ofsld_rd_port
  import ofsld_pkg::*;
#(
  parameter int OFS_W = 18,
  parameter int NB    = 3,
  parameter int SP_W  = 3
) (
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             ren,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic [7:0]       rd_q,
  output logic [SP_W-1:0]  rstep
);

  localparam int              NSTEP     = 2 * NB;
  localparam logic [SP_W-1:0] STEP_LAST = SP_W'(NSTEP - 1);
  localparam int              TOP_BITS  = OFS_W - 8 * (NB - 1);
  localparam logic [7:0]      TOP_KEEP  = 8'((1 << TOP_BITS) - 1);

  logic       rd_go, pick_af;
  int         ridx;
  logic [7:0] rd_byte;

  assign rd_go = ld & ren;

  always_comb begin
    pick_af = (int'(rstep) >= NB);
    ridx    = pick_af ? int'(rstep) - NB : int'(rstep);
    rd_byte = pick_byte(pick_af ? word_t'(af_ofs) : word_t'(ae_ofs), ridx);
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rstep <= '0;
      rd_q  <= '0;
    end else if (!ld) begin
      rstep <= '0;
    end else if (rd_go) begin
      rd_q  <= rd_byte;
      rstep <= (rstep == STEP_LAST) ? '0 : rstep + 1'b1;
    end
  end

  AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_go |=> $stable(rd_q));  // R5
  AST_RD_RESTART: assert property (@(posedge rclk) disable iff (!rst_n)
    !ld |=> rstep == '0);  // R6
  AST_TOP_PAD: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_go && int'(rstep) % NB == NB - 1) |=> (rd_q & ~TOP_KEEP) == 8'h00);  // R4
  AST_RSTEP_RANGE: assert property (@(posedge rclk) disable iff (!rst_n)
    rstep <= STEP_LAST);  // R5

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int               OFS_W  = 18,
  parameter logic [OFS_W-1:0] DEF_AE = OFS_W'(127),
  parameter logic [OFS_W-1:0] DEF_AF = OFS_W'(255)
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             wen,
  input  logic             sen,
  input  logic             si,
  input  logic [7:0]       wr_d,
  input  logic             ren,
  output logic [7:0]       rd_q,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);

  // OFS_W is expected in 9..32.
  localparam int NB    = ofsld_pkg::byte_count(OFS_W);
  localparam int NSTEP = 2 * NB;
  localparam int SP_W  = $clog2(NSTEP);
  localparam int SB_W  = $clog2(2 * OFS_W);

  logic            par_we, ser_we;
  logic [SP_W-1:0] wstep, rstep;
  logic [SB_W-1:0] sbit;

  ofsld_wr_seq #(.OFS_W(OFS_W), .NSTEP(NSTEP), .SP_W(SP_W), .SB_W(SB_W)) u_seq (
    .wclk(wclk), .rst_n(rst_n), .ld(ld), .wen(wen), .sen(sen),
    .par_we(par_we), .ser_we(ser_we), .wstep(wstep), .sbit(sbit)
  );

  ofsld_regs #(.OFS_W(OFS_W), .NB(NB), .SP_W(SP_W), .SB_W(SB_W),
               .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_regs (
    .wclk(wclk), .rst_n(rst_n), .par_we(par_we), .ser_we(ser_we),
    .wstep(wstep), .sbit(sbit), .wr_d(wr_d), .si(si),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  ofsld_rd_port #(.OFS_W(OFS_W), .NB(NB), .SP_W(SP_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ld(ld), .ren(ren),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_q(rd_q), .rstep(rstep)
  );

  AST_NO_DUAL_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0({par_we, ser_we}));  // R7

endmodule

// File: tb/flag_offset_loader_test.sv
`timescale 1ns/1ps
module flag_offset_loader_test;

  localparam int W = 18;
  localparam logic [W-1:0] D_AE = W'(127);
  localparam logic [W-1:0] D_AF = W'(255);

  logic clk = 0;
  logic rst_n, ld, wen, sen, si, ren;
  logic [7:0] wr_d, rd_q;
  logic [W-1:0] ae_ofs, af_ofs;

  always #2 clk = ~clk;

  flag_offset_loader #(.OFS_W(W), .DEF_AE(D_AE), .DEF_AF(D_AF)) uut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .ld(ld), .wen(wen), .sen(sen),
    .si(si), .wr_d(wr_d), .ren(ren), .rd_q(rd_q), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] m_ae, m_af;
  logic [7:0] m_rd;
  int wpos, spos, rpos;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Byte n of the six-step order, computed bit by bit.
  function automatic logic [7:0] model_byte(int step);
    logic [7:0] b;
    int base;
    base = 8 * (step % 3);
    for (int k = 0; k < 8; k++)
      b[k] = (base + k < W) ? ((step < 3) ? m_ae[base + k] : m_af[base + k]) : 1'b0;
    return b;
  endfunction

  task automatic tick(string req, logic l, logic w, logic s, logic r,
                      logic [7:0] d, logic b);
    ld = l; wen = w; sen = s; ren = r; wr_d = d; si = b;
    if (!l) begin
      wpos = 0; spos = 0; rpos = 0;
    end else begin
      if (r) begin
        m_rd = model_byte(rpos);
        rpos = (rpos + 1) % 6;
      end
      if (w) begin
        for (int k = 0; k < 8; k++) begin
          int p;
          p = 8 * (wpos % 3) + k;
          if (p < W) begin
            if (wpos < 3) m_ae[p] = d[k];
            else          m_af[p] = d[k];
          end
        end
        wpos = (wpos + 1) % 6;
      end else if (s) begin
        if (spos < W) m_ae[spos] = b;
        else          m_af[spos - W] = b;
        spos = (spos + 1) % (2 * W);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req, "ae_ofs", 32'(ae_ofs), 32'(m_ae));
    check(req, "af_ofs", 32'(af_ofs), 32'(m_af));
    check(req, "rd_q", 32'(rd_q), 32'(m_rd));
  endtask

  task automatic idle(string req);
    tick(req, 0, 0, 0, 0, 8'h00, 0);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 6; i++) tick(req, 1, 0, 0, 1, 8'h00, 0);
    idle(req);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; ld = 0; wen = 0; sen = 0; ren = 0; wr_d = 0; si = 0;
    m_ae = D_AE; m_af = D_AF; m_rd = 0; wpos = 0; spos = 0; rpos = 0;
    repeat (3) @(negedge clk);
    check("R1", "ae_ofs in reset", 32'(ae_ofs), 32'(D_AE));
    check("R1", "af_ofs in reset", 32'(af_ofs), 32'(D_AF));
    check("R1", "rd_q in reset", 32'(rd_q), 32'h0);
    rst_n = 1;
    idle("R1");
    // R1/R5: readback of default offsets starting at step 0
    read_all("R1");

    // R3/R4: parallel load sweeps, all-ones top byte in round 0
    for (int rnd = 0; rnd < 8; rnd++) begin
      for (int st = 0; st < 6; st++) begin
        logic [7:0] v;
        v = (rnd == 0) ? 8'hFF : 8'((rnd * 37 + st * 11) ^ 8'hA5);
        tick("R3", 1, 1, 0, 0, v, 0);
      end
      idle("R3");
      read_all("R4");
    end

    // R3: seventh byte wraps onto almost-empty byte 0
    for (int st = 0; st < 7; st++) tick("R3", 1, 1, 0, 0, 8'(8'h10 + st), 0);
    idle("R3");
    read_all("R5");

    // R6: dropping ld mid-sequence restarts the write step
    tick("R6", 1, 1, 0, 0, 8'h3C, 0);
    tick("R6", 1, 1, 0, 0, 8'hC3, 0);
    idle("R6");
    tick("R6", 1, 1, 0, 0, 8'h5A, 0);
    idle("R6");
    // R6: read restart
    tick("R6", 1, 0, 0, 1, 8'h00, 0);
    tick("R6", 1, 0, 0, 1, 8'h00, 0);
    idle("R6");
    tick("R6", 1, 0, 0, 1, 8'h00, 0);
    idle("R6");

    // R2: serial load patterns, then five bits of wrap
    for (int rnd = 0; rnd < 3; rnd++) begin
      for (int i = 0; i < 2 * W; i++) tick("R2", 1, 0, 1, 0, 8'h00, 1'((i * 7 + rnd) % 3 == 0));
      for (int i = 0; i < ((rnd == 2) ? 5 : 0); i++) tick("R2", 1, 0, 1, 0, 8'h00, 1'(i % 2));
      idle("R2");
      read_all("R2");
    end
    // R6: serial restart after ld drop
    for (int i = 0; i < 4; i++) tick("R6", 1, 0, 1, 0, 8'h00, 1'b1);
    idle("R6");
    tick("R6", 1, 0, 1, 0, 8'h00, 1'b0);
    idle("R6");

    // R7: wen and sen together: byte only, serial position held
    tick("R7", 1, 0, 1, 0, 8'h00, 1'b1);
    tick("R7", 1, 1, 1, 0, 8'h81, 1'b0);
    tick("R7", 1, 0, 1, 0, 8'h00, 1'b0);
    idle("R7");

    // R8: activity without ld changes nothing
    for (int i = 0; i < 6; i++) tick("R8", 0, 1'(i % 2), 1, 1, 8'(8'hE0 + i), 1'(i % 3 == 0));

    // R9: reads and writes interleaved in one session
    tick("R9", 1, 0, 0, 1, 8'h00, 0);
    tick("R9", 1, 0, 0, 1, 8'h00, 0);
    tick("R9", 1, 1, 0, 0, 8'h96, 0);
    tick("R9", 1, 0, 0, 1, 8'h00, 0);
    tick("R9", 1, 1, 0, 1, 8'h69, 0);
    tick("R9", 1, 0, 0, 1, 8'h00, 0);
    idle("R9");
    read_all("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule